// File: doc/BRIEF.md
# Ring Bus Download Node

This block is the receiving end of one card on a single-loop download bus. Every card on the loop sees the same byte stream. Each byte carries a two-bit tag that marks it as a command, a card address, an area address or a data byte. A start command arms every node, whatever its identity. A card address then selects the one node whose strapped ID matches it. That node takes an area address to pick a partition of its nonvolatile store. It then turns data bytes into single-cycle write strobes, each carrying a partition index and a running write offset.

The host sends at most one burst of data (2048 bytes by default) to a card, then moves on to another card's address. This lets one card program its flash while the others receive data. A node closes its data channel after a full burst and stays closed until it sees a new card address. Each partition has its own offset counter, and it keeps counting across bursts, so a card that is addressed again appends to what it already holds. The flash stub drives a busy input. A data byte that arrives while busy is high is dropped and sets a sticky error flag. An end command returns every node to idle.

Top module: `ring_dl_node`

## Requirements
- R1: After reset, dl_active, selected, wr_en and overrun_err are all 0.
- R2: A command byte (tag 2'b00) with value 8'hA5 sets dl_active on every node, whatever node_id is, and clears selected. Any other command value except 8'h5A changes nothing.
- R3: A card address byte (tag 2'b01) received while dl_active is 1 sets selected to 1 if the byte equals node_id, and to 0 otherwise. A card address received while idle is ignored.
- R4: An area address byte (tag 2'b10) received while selected picks partition number equal to the byte's value. A value of NUM_PARTS or more leaves no valid partition, and the data bytes that follow are dropped.
- R5: A data byte (tag 2'b11) accepted while selected, with a valid partition and flash_busy low, produces a wr_en pulse one cycle later. The pulse carries wr_data equal to the byte, wr_part equal to the partition and wr_addr equal to that partition's offset. The offset then advances by one.
- R6: A node that is not selected produces no write for data bytes.
- R7: Once BURST_BYTES data bytes have been written since the last card address, further data bytes are dropped until a new card address arrives.
- R8: Partition offsets are not reset by card or area addresses, so a node that is addressed again continues from where each partition stopped.
- R9: A data byte that would otherwise be written while flash_busy is high is dropped (no wr_en) and sets overrun_err. overrun_err then stays 1 until reset.
- R10: A command byte with value 8'hA5's companion 8'h5A clears dl_active and selected, and data bytes that follow produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | DATA_W | Strapped identity of this card |
| rx_valid | input | 1 | A bus byte is present this cycle |
| rx_tag | input | 2 | Byte class: 00 command, 01 card address, 10 area address, 11 data |
| rx_byte | input | DATA_W | Bus byte value |
| flash_busy | input | 1 | Store is programming and cannot take data |
| wr_en | output | 1 | Write strobe to the store |
| wr_part | output | PART_W | Partition index of the write |
| wr_addr | output | OFFS_W | Offset inside the partition |
| wr_data | output | DATA_W | Byte to write |
| dl_active | output | 1 | Node is in the download state |
| selected | output | 1 | Card address matched node_id |
| overrun_err | output | 1 | Sticky: data arrived while the store was busy |

## Verification
Every result appears exactly one clock after the edge that samples the byte. State flags, write strobes and the error flag are all registered once. The bench presents each byte on a falling edge and removes it on the next falling edge. It reads the outputs at that second falling edge, which is one edge after sampling, where both the strobe and the new state are due. Dropped bytes are confirmed the same way: wr_en is read low at that edge and the offset is read back through the next accepted write.

// File: rtl/ring_dl_pkg.sv
package ring_dl_pkg;

   typedef enum logic [1:0] {
      TAG_CMD  = 2'b00,
      TAG_CARD = 2'b01,
      TAG_AREA = 2'b10,
      TAG_DATA = 2'b11
   } tag_e;

   localparam logic [7:0] CMD_BEGIN  = 8'hA5;
   localparam logic [7:0] CMD_FINISH = 8'h5A;

endpackage

// File: rtl/ring_dl_ctrl.sv
module ring_dl_ctrl
   import ring_dl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int NUM_PARTS   = 4,
   parameter int BURST_BYTES = 2048,
   localparam int PART_W     = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1,
   localparam int BCNT_W     = $clog2(BURST_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] node_id,
   input  logic              rx_valid,
   input  logic [1:0]        rx_tag,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              flash_busy,
   output logic              dl_active,
   output logic              selected,
   output logic [PART_W-1:0] part_idx,
   output logic              wr_fire,
   output logic              ovr_hit
);

   localparam logic [BCNT_W-1:0] BURST_LIM = BCNT_W'(BURST_BYTES);
   localparam logic [DATA_W-1:0] OP_BEGIN  = DATA_W'(CMD_BEGIN);
   localparam logic [DATA_W-1:0] OP_FINISH = DATA_W'(CMD_FINISH);

   logic              part_ok;
   logic [BCNT_W-1:0] burst_cnt;
   logic              is_cmd, is_card, is_area, is_data;
   logic              area_in_range;
   logic              accept;

   assign is_cmd  = rx_valid && (rx_tag == TAG_CMD);
   assign is_card = rx_valid && (rx_tag == TAG_CARD);
   assign is_area = rx_valid && (rx_tag == TAG_AREA);
   assign is_data = rx_valid && (rx_tag == TAG_DATA);

   assign area_in_range = ({{(32-DATA_W){1'b0}}, rx_byte} < NUM_PARTS);

   assign accept  = is_data && dl_active && selected && part_ok
                    && (burst_cnt != BURST_LIM);
   assign wr_fire = accept && !flash_busy;
   assign ovr_hit = accept && flash_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dl_active <= 1'b0;
         selected  <= 1'b0;
         part_ok   <= 1'b0;
         part_idx  <= '0;
         burst_cnt <= '0;
      end else begin
         if (is_cmd && rx_byte == OP_BEGIN) begin
            dl_active <= 1'b1;
            selected  <= 1'b0;
            part_ok   <= 1'b0;
            burst_cnt <= '0;
         end else if (is_cmd && rx_byte == OP_FINISH) begin
            dl_active <= 1'b0;
            selected  <= 1'b0;
            part_ok   <= 1'b0;
            burst_cnt <= '0;
         end else if (is_card && dl_active) begin
            selected  <= (rx_byte == node_id);
            part_ok   <= 1'b0;
            burst_cnt <= '0;
         end else if (is_area && dl_active && selected) begin
            part_ok   <= area_in_range;
            part_idx  <= rx_byte[PART_W-1:0];
         end else if (wr_fire) begin
            burst_cnt <= burst_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ring_dl_offsets.sv
module ring_dl_offsets #(
   parameter int NUM_PARTS = 4,
   parameter int OFFS_W    = 20,
   localparam int PART_W   = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bump,
   input  logic [PART_W-1:0] part_idx,
   output logic [OFFS_W-1:0] cur_off
);

   logic [NUM_PARTS-1:0][OFFS_W-1:0] offs;

   for (genvar gi = 0; gi < NUM_PARTS; gi++) begin : g_part
      logic [OFFS_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (bump && part_idx == PART_W'(gi))
            cnt <= cnt + 1'b1;
      end
      assign offs[gi] = cnt;
   end

   always_comb begin
      cur_off = '0;
      for (int i = 0; i < NUM_PARTS; i++)
         if (part_idx == PART_W'(i))
            cur_off = offs[i];
   end

endmodule

// File: rtl/ring_dl_wport.sv
module ring_dl_wport #(
   parameter int DATA_W = 8,
   parameter int PART_W = 2,
   parameter int OFFS_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              ovr_hit,
   input  logic [DATA_W-1:0] data_in,
   input  logic [PART_W-1:0] part_in,
   input  logic [OFFS_W-1:0] off_in,
   output logic              wr_en,
   output logic [PART_W-1:0] wr_part,
   output logic [OFFS_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              overrun_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en       <= 1'b0;
         wr_part     <= '0;
         wr_addr     <= '0;
         wr_data     <= '0;
         overrun_err <= 1'b0;
      end else begin
         wr_en <= fire;
         if (fire) begin
            wr_part <= part_in;
            wr_addr <= off_in;
            wr_data <= data_in;
         end
         if (ovr_hit)
            overrun_err <= 1'b1;
      end
   end

endmodule

// File: rtl/ring_dl_node.sv
module ring_dl_node #(
   parameter int DATA_W      = 8,
   parameter int NUM_PARTS   = 4,
   parameter int BURST_BYTES = 2048,
   parameter int OFFS_W      = 20,
   localparam int PART_W     = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] node_id,
   input  logic              rx_valid,
   input  logic [1:0]        rx_tag,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              flash_busy,
   output logic              wr_en,
   output logic [PART_W-1:0] wr_part,
   output logic [OFFS_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              dl_active,
   output logic              selected,
   output logic              overrun_err
);

   if (DATA_W < 8 || DATA_W > 31) begin : g_bad_data_w
      $error("ring_dl_node: DATA_W must be 8..31");
   end
   if (NUM_PARTS < 1 || PART_W > DATA_W) begin : g_bad_parts
      $error("ring_dl_node: NUM_PARTS out of range");
   end
   if (BURST_BYTES < 1) begin : g_bad_burst
      $error("ring_dl_node: BURST_BYTES must be positive");
   end
   if (OFFS_W < 1) begin : g_bad_offs
      $error("ring_dl_node: OFFS_W must be positive");
   end

   logic              fire;
   logic              ovr_hit;
   logic [PART_W-1:0] part_idx;
   logic [OFFS_W-1:0] cur_off;

   ring_dl_ctrl #(
      .DATA_W(DATA_W), .NUM_PARTS(NUM_PARTS), .BURST_BYTES(BURST_BYTES)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .node_id(node_id),
      .rx_valid(rx_valid), .rx_tag(rx_tag), .rx_byte(rx_byte),
      .flash_busy(flash_busy), .dl_active(dl_active), .selected(selected),
      .part_idx(part_idx), .wr_fire(fire), .ovr_hit(ovr_hit)
   );

   ring_dl_offsets #(
      .NUM_PARTS(NUM_PARTS), .OFFS_W(OFFS_W)
   ) i_offs (
      .clk(clk), .rst_n(rst_n), .bump(fire), .part_idx(part_idx),
      .cur_off(cur_off)
   );

   ring_dl_wport #(
      .DATA_W(DATA_W), .PART_W(PART_W), .OFFS_W(OFFS_W)
   ) i_wport (
      .clk(clk), .rst_n(rst_n), .fire(fire), .ovr_hit(ovr_hit),
      .data_in(rx_byte), .part_in(part_idx), .off_in(cur_off),
      .wr_en(wr_en), .wr_part(wr_part), .wr_addr(wr_addr),
      .wr_data(wr_data), .overrun_err(overrun_err)
   );

endmodule

// File: rtl/ring_dl_node_chk.sv
module ring_dl_node_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] node_id,
   input logic              rx_valid,
   input logic [1:0]        rx_tag,
   input logic [DATA_W-1:0] rx_byte,
   input logic              flash_busy,
   input logic              wr_en,
   input logic              dl_active,
   input logic              selected,
   input logic              overrun_err
);

   localparam logic [DATA_W-1:0] OP_BEGIN  = DATA_W'(8'hA5);
   localparam logic [DATA_W-1:0] OP_FINISH = DATA_W'(8'h5A);

   AST_BEGIN_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_tag == 2'b00 && rx_byte == OP_BEGIN) |=> (dl_active && !selected)); // R2

   AST_CARD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_tag == 2'b01 && dl_active) |=> (selected == ($past(rx_byte) == $past(node_id)))); // R3

   AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(selected)); // R6

   AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(rx_valid && rx_tag == 2'b11)); // R5

   AST_NO_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$past(flash_busy)); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_err |=> overrun_err); // R9

   AST_FINISH_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_tag == 2'b00 && rx_byte == OP_FINISH) |=> (!dl_active && !selected)); // R10

   AST_SEL_IN_DL: assert property (@(posedge clk) disable iff (!rst_n)
      selected |-> dl_active); // R3

endmodule

bind ring_dl_node ring_dl_node_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .node_id(node_id), .rx_valid(rx_valid),
   .rx_tag(rx_tag), .rx_byte(rx_byte), .flash_busy(flash_busy),
   .wr_en(wr_en), .dl_active(dl_active), .selected(selected),
   .overrun_err(overrun_err)
);

// File: tb/test_ring_dl_node.sv
`timescale 1ns/1ps
module test_ring_dl_node;

   localparam int DATA_W = 8;
   localparam int NUM_PARTS = 4;
   localparam int BURST = 2048;
   localparam int OFFS_W = 20;
   localparam logic [7:0] MY_ID = 8'h05;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] node_id = MY_ID;
   logic              rx_valid = 1'b0;
   logic [1:0]        rx_tag = 2'b00;
   logic [DATA_W-1:0] rx_byte = '0;
   logic              flash_busy = 1'b0;
   logic              wr_en;
   logic [1:0]        wr_part;
   logic [OFFS_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              dl_active, selected, overrun_err;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ring_dl_node #(
      .DATA_W(DATA_W), .NUM_PARTS(NUM_PARTS), .BURST_BYTES(BURST), .OFFS_W(OFFS_W)
   ) i_ring_dl_node (
      .clk(clk), .rst_n(rst_n), .node_id(node_id), .rx_valid(rx_valid),
      .rx_tag(rx_tag), .rx_byte(rx_byte), .flash_busy(flash_busy),
      .wr_en(wr_en), .wr_part(wr_part), .wr_addr(wr_addr), .wr_data(wr_data),
      .dl_active(dl_active), .selected(selected), .overrun_err(overrun_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // byte on a falling edge, removed one falling edge later; outputs are due then
   task automatic send(input logic [1:0] t, input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_tag = t; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 dl_active", 32'(dl_active), 0);
      chk("R1 selected", 32'(selected), 0);
      chk("R1 wr_en", 32'(wr_en), 0);
      chk("R1 overrun_err", 32'(overrun_err), 0);
   endtask

   task automatic t_idle_ignore;
      send(2'b00, 8'h33);
      chk("R2 unknown command", 32'(dl_active), 0);
      send(2'b01, MY_ID);
      chk("R3 card address while idle", 32'(selected), 0);
      send(2'b11, 8'h77);
      chk("R6 data while idle", 32'(wr_en), 0);
   endtask

   task automatic t_start;
      node_id = 8'h09;                 // arming does not depend on identity
      send(2'b00, 8'hA5);
      chk("R2 begin arms", 32'(dl_active), 1);
      node_id = MY_ID;
      send(2'b00, 8'h33);
      chk("R2 unknown command keeps state", 32'(dl_active), 1);
   endtask

   task automatic t_match;
      send(2'b01, MY_ID);
      chk("R3 match", 32'(selected), 1);
      send(2'b10, 8'd2);
      send(2'b11, 8'h11);
      chk("R5 wr_en", 32'(wr_en), 1);
      chk("R4 wr_part", 32'(wr_part), 2);
      chk("R5 wr_addr", 32'(wr_addr), 0);
      chk("R5 wr_data", 32'(wr_data), 32'h11);
      send(2'b11, 8'h22);
      chk("R5 second addr", 32'(wr_addr), 1);
      chk("R5 second data", 32'(wr_data), 32'h22);
   endtask

   task automatic t_bad_area;
      send(2'b10, 8'd7);
      send(2'b11, 8'h44);
      chk("R4 out-of-range area drops", 32'(wr_en), 0);
   endtask

   task automatic t_mismatch;
      send(2'b01, 8'h06);
      chk("R3 mismatch", 32'(selected), 0);
      send(2'b10, 8'd1);
      send(2'b11, 8'h55);
      chk("R6 unselected drops", 32'(wr_en), 0);
   endtask

   task automatic t_busy;
      send(2'b01, MY_ID);
      send(2'b10, 8'd1);
      flash_busy = 1'b1;
      send(2'b11, 8'h66);
      chk("R9 busy drops", 32'(wr_en), 0);
      chk("R9 overrun set", 32'(overrun_err), 1);
      flash_busy = 1'b0;
      send(2'b11, 8'h67);
      chk("R9 after busy write", 32'(wr_en), 1);
      chk("R9 dropped byte used no offset", 32'(wr_addr), 0);
      chk("R9 overrun sticky", 32'(overrun_err), 1);
   endtask

   task automatic t_burst;
      int bad = 0;
      send(2'b01, MY_ID);
      send(2'b10, 8'd0);
      for (int i = 0; i < BURST; i++) begin
         send(2'b11, 8'(i));
         if (wr_en !== 1'b1 || wr_addr !== OFFS_W'(i)) bad++;
      end
      chk("R7 full burst written", 32'(bad), 0);
      send(2'b11, 8'hEE);
      chk("R7 byte past burst dropped", 32'(wr_en), 0);
      send(2'b10, 8'd0);
      send(2'b11, 8'hEF);
      chk("R7 area byte does not reopen", 32'(wr_en), 0);
      send(2'b01, MY_ID);
      send(2'b10, 8'd0);
      send(2'b11, 8'hAB);
      chk("R8 reopened write", 32'(wr_en), 1);
      chk("R8 append partition 0", 32'(wr_addr), BURST);
      send(2'b10, 8'd2);
      send(2'b11, 8'hCD);
      chk("R8 append partition 2", 32'(wr_addr), 2);
   endtask

   task automatic t_end;
      send(2'b00, 8'h5A);
      chk("R10 dl_active cleared", 32'(dl_active), 0);
      chk("R10 selected cleared", 32'(selected), 0);
      send(2'b11, 8'h99);
      chk("R10 data after finish", 32'(wr_en), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_idle_ignore;
      t_start;
      t_match;
      t_bad_area;
      t_mismatch;
      t_busy;
      t_burst;
      t_end;
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule